// File: doc/BRIEF.md
# Packet Router Input Controller

This block is the sequencing state machine on the receive side of a one-input, four-output packet router. A packet arrives as a header byte, then one or more payload bytes, then a parity byte. The low address bits of the header select one of the output FIFOs. The controller issues one strobe per phase of the packet to the datapath: address decode, header load, payload load, full stall, resume after full, parity load and parity check. It also drives a busy flag that tells the source to hold its current byte.

The controller starts a packet only when the selected FIFO reports empty. Until then it waits with busy raised. If the shared FIFO-full flag rises during the payload, the controller stalls. When the flag clears it passes through a one-cycle resume state. That state either returns to the payload or moves on to the parity byte. A soft-reset pulse for the selected port abandons the packet and returns the controller to address decode. All inputs are sampled on the rising clock edge. The strobes are decoded from the registered state, so each one changes in the cycle after the edge that moved the state.

Top module: `pkt_rx_ctrl`

## Requirements
- R1: After reset, detect_o is 1, busy_o is 0 and every other strobe is 0.
- R2: In decode, with pkt_valid_i high at an edge, dest_o takes hdr_addr_i at that edge. All four values 0 to 3 are legal. If fifo_empty_i bit hdr_addr_i is 1 at that edge, hdr_ld_o is 1 in the following cycle.
- R3: If that empty bit is 0, the controller enters a wait cycle. In the wait cycle busy_o is 1 and all strobes are 0. It stays there until fifo_empty_i bit dest_o is seen as 1 at an edge. hdr_ld_o follows in the next cycle.
- R4: pay_ld_o follows hdr_ld_o one cycle later. It stays high while pkt_valid_i is 1 and fifo_full_i is 0.
- R5: fifo_full_i at 1 during pay_ld_o gives stall_o in the next cycle. stall_o holds while fifo_full_i stays 1. The edge that first sees fifo_full_i at 0 gives resume_o for exactly one cycle. fifo_full_i takes priority over a falling pkt_valid_i.
- R6: From resume_o, pkt_valid_i at 1 returns to pay_ld_o and pkt_valid_i at 0 goes to par_ld_o.
- R7: When pkt_valid_i is 0 during pay_ld_o, the next three cycles show par_ld_o, then chk_o, then detect_o.
- R8: busy_o is 0 only while detect_o or pay_ld_o is high.
- R9: In any state other than decode, soft_rst_i bit dest_o returns the controller to decode in the next cycle. A soft reset of any other port, or any soft reset while in decode, has no effect.
- R10: At most one of the seven strobes is high in any cycle.
- R11: dest_o keeps its value from capture until the controller is back in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | Source has a packet byte on the bus |
| hdr_addr_i | input | 2 | Destination field, low bits of the header byte |
| fifo_empty_i | input | 4 | Empty flag of each output FIFO |
| fifo_full_i | input | 1 | Combined full flag of the FIFOs |
| soft_rst_i | input | 4 | Per-port soft reset pulse |
| detect_o | output | 1 | Address decode state |
| hdr_ld_o | output | 1 | Load header byte |
| pay_ld_o | output | 1 | Load payload byte |
| stall_o | output | 1 | FIFO-full stall |
| resume_o | output | 1 | Load held byte after full clears |
| par_ld_o | output | 1 | Load parity byte |
| chk_o | output | 1 | Check parity |
| busy_o | output | 1 | Source must hold its byte |
| dest_o | output | 2 | Latched destination port |

## Verification
The bench sweeps every destination together with empty-wait lengths, payload lengths, the position of a full stall and its length. A controller that read the wrong empty bit, or refused destination 3, would load the header early or stall forever. A controller that let a falling pkt_valid_i win over fifo_full_i would skip the stall and go to parity while data is still held. Stalls on the last payload byte exercise both exits of the resume state, which catches a resume state that always returns to the payload. Soft-reset pulses on the wrong port, and pulses while in decode, must leave the state unchanged. A controller that ignored the latched destination would abandon a live packet or hang in wait.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  typedef enum logic [2:0] {
    ST_DECODE, ST_WAIT, ST_HDR, ST_DATA, ST_FULL, ST_RESUME, ST_PAR, ST_CHECK
  } rx_state_e;
  localparam int unsigned NUM_ST = 8;
endpackage

// File: rtl/pkt_dest_sel.sv
module pkt_dest_sel #(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned DEST_W = $clog2(NUM_PORTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cap_en_i,
  input  logic [DEST_W-1:0]    hdr_addr_i,
  input  logic [NUM_PORTS-1:0] fifo_empty_i,
  input  logic [NUM_PORTS-1:0] soft_rst_i,
  output logic [DEST_W-1:0]    dest_o,
  output logic                 hdr_empty_o,
  output logic                 dest_empty_o,
  output logic                 dest_srst_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dest_o <= '0;
    else if (cap_en_i) dest_o <= hdr_addr_i;
  end

  assign hdr_empty_o  = fifo_empty_i[hdr_addr_i];
  assign dest_empty_o = fifo_empty_i[dest_o];
  assign dest_srst_o  = soft_rst_i[dest_o];
endmodule

// File: rtl/pkt_rx_fsm.sv
module pkt_rx_fsm
  import pkt_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pkt_valid_i,
  input  logic      hdr_empty_i,
  input  logic      dest_empty_i,
  input  logic      dest_srst_i,
  input  logic      fifo_full_i,
  output rx_state_e state_o
);
  rx_state_e nxt;

  always_comb begin
    nxt = state_o;
    unique case (state_o)
      ST_DECODE: if (pkt_valid_i) nxt = hdr_empty_i ? ST_HDR : ST_WAIT;
      ST_WAIT:   if (dest_empty_i) nxt = ST_HDR;
      ST_HDR:    nxt = ST_DATA;
      ST_DATA: begin
        if (fifo_full_i)       nxt = ST_FULL;  // full wins over end of packet
        else if (!pkt_valid_i) nxt = ST_PAR;
      end
      ST_FULL:   if (!fifo_full_i) nxt = ST_RESUME;
      ST_RESUME: nxt = pkt_valid_i ? ST_DATA : ST_PAR;
      ST_PAR:    nxt = ST_CHECK;
      ST_CHECK:  nxt = ST_DECODE;
      default:   nxt = ST_DECODE;
    endcase
    if (state_o != ST_DECODE && dest_srst_i) nxt = ST_DECODE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_DECODE;
    else         state_o <= nxt;
  end
endmodule

// File: rtl/pkt_strobe_dec.sv
module pkt_strobe_dec
  import pkt_rx_pkg::*;
(
  input  rx_state_e state_i,
  output logic      detect_o,
  output logic      hdr_ld_o,
  output logic      pay_ld_o,
  output logic      stall_o,
  output logic      resume_o,
  output logic      par_ld_o,
  output logic      chk_o,
  output logic      busy_o
);
  logic [NUM_ST-1:0] hot;

  for (genvar k = 0; k < NUM_ST; k++) begin : g_hot
    assign hot[k] = (state_i == rx_state_e'(k));
  end

  assign detect_o = hot[ST_DECODE];
  assign hdr_ld_o = hot[ST_HDR];
  assign pay_ld_o = hot[ST_DATA];
  assign stall_o  = hot[ST_FULL];
  assign resume_o = hot[ST_RESUME];
  assign par_ld_o = hot[ST_PAR];
  assign chk_o    = hot[ST_CHECK];
  // source may advance only while decoding or streaming payload
  assign busy_o   = ~(hot[ST_DECODE] | hot[ST_DATA]);
endmodule

// File: rtl/pkt_rx_ctrl.sv
module pkt_rx_ctrl
  import pkt_rx_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned DEST_W = $clog2(NUM_PORTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pkt_valid_i,
  input  logic [DEST_W-1:0]    hdr_addr_i,
  input  logic [NUM_PORTS-1:0] fifo_empty_i,
  input  logic                 fifo_full_i,
  input  logic [NUM_PORTS-1:0] soft_rst_i,
  output logic                 detect_o,
  output logic                 hdr_ld_o,
  output logic                 pay_ld_o,
  output logic                 stall_o,
  output logic                 resume_o,
  output logic                 par_ld_o,
  output logic                 chk_o,
  output logic                 busy_o,
  output logic [DEST_W-1:0]    dest_o
);
  rx_state_e state;
  logic      hdr_empty, dest_empty, dest_srst, cap_en;

  assign cap_en = (state == ST_DECODE) && pkt_valid_i;

  pkt_dest_sel #(.NUM_PORTS(NUM_PORTS)) u_dest (
    .clk_i, .rst_ni, .cap_en_i(cap_en), .hdr_addr_i, .fifo_empty_i, .soft_rst_i,
    .dest_o, .hdr_empty_o(hdr_empty), .dest_empty_o(dest_empty),
    .dest_srst_o(dest_srst)
  );

  pkt_rx_fsm u_fsm (
    .clk_i, .rst_ni, .pkt_valid_i, .hdr_empty_i(hdr_empty),
    .dest_empty_i(dest_empty), .dest_srst_i(dest_srst), .fifo_full_i,
    .state_o(state)
  );

  pkt_strobe_dec u_dec (
    .state_i(state), .detect_o, .hdr_ld_o, .pay_ld_o, .stall_o, .resume_o,
    .par_ld_o, .chk_o, .busy_o
  );
endmodule

// File: rtl/pkt_rx_ctrl_chk.sv
module pkt_rx_ctrl_chk #(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned DEST_W = $clog2(NUM_PORTS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 pkt_valid_i,
  input logic [DEST_W-1:0]    hdr_addr_i,
  input logic [NUM_PORTS-1:0] fifo_empty_i,
  input logic                 fifo_full_i,
  input logic [NUM_PORTS-1:0] soft_rst_i,
  input logic                 detect_o,
  input logic                 hdr_ld_o,
  input logic                 pay_ld_o,
  input logic                 stall_o,
  input logic                 resume_o,
  input logic                 par_ld_o,
  input logic                 chk_o,
  input logic                 busy_o,
  input logic [DEST_W-1:0]    dest_o
);
  logic idle_wait, srst_hit;
  assign idle_wait = busy_o && !(hdr_ld_o | stall_o | resume_o | par_ld_o | chk_o);
  assign srst_hit  = soft_rst_i[dest_o];

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({detect_o, hdr_ld_o, pay_ld_o, stall_o, resume_o, par_ld_o, chk_o})); // R10
  AST_HDR_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o && pkt_valid_i && fifo_empty_i[hdr_addr_i] |=> hdr_ld_o); // R2
  AST_WAIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_wait && !fifo_empty_i[dest_o] && !srst_hit |=> idle_wait); // R3
  AST_HDR_TO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_ld_o && !srst_hit |=> pay_ld_o); // R4
  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_ld_o && fifo_full_i && !srst_hit |=> stall_o); // R5
  AST_RESUME_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o && pkt_valid_i && !srst_hit |=> pay_ld_o); // R6
  AST_PAR_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_ld_o && !srst_hit |=> chk_o); // R7
  AST_CHK_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_o |=> detect_o); // R7
  AST_SOFT_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !detect_o && srst_hit |=> detect_o); // R9
  AST_DEST_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !detect_o |=> $stable(dest_o)); // R11
endmodule

bind pkt_rx_ctrl pkt_rx_ctrl_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pkt_valid_i(pkt_valid_i),
  .hdr_addr_i(hdr_addr_i), .fifo_empty_i(fifo_empty_i),
  .fifo_full_i(fifo_full_i), .soft_rst_i(soft_rst_i), .detect_o(detect_o),
  .hdr_ld_o(hdr_ld_o), .pay_ld_o(pay_ld_o), .stall_o(stall_o),
  .resume_o(resume_o), .par_ld_o(par_ld_o), .chk_o(chk_o), .busy_o(busy_o),
  .dest_o(dest_o)
);

// File: tb/sim_pkt_rx_ctrl.sv
`timescale 1ns/1ps
module sim_pkt_rx_ctrl;
  localparam int E_DEC = 0, E_WAIT = 1, E_HDR = 2, E_DATA = 3,
                 E_FULL = 4, E_RES = 5, E_PAR = 6, E_CHK = 7;

  logic       clk_i = 0, rst_ni = 0;
  logic       pkt_valid_i = 0, fifo_full_i = 0;
  logic [1:0] hdr_addr_i = 0;
  logic [3:0] fifo_empty_i = 4'hF, soft_rst_i = 0;
  logic       detect_o, hdr_ld_o, pay_ld_o, stall_o, resume_o, par_ld_o, chk_o, busy_o;
  logic [1:0] dest_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  pkt_rx_ctrl u0 (.*);

  // expected {detect,hdr,pay,stall,resume,par,chk,busy} per bench phase
  function automatic logic [7:0] exp_of(int ph);
    case (ph)
      E_DEC:  return 8'b1000_0000;
      E_WAIT: return 8'b0000_0001;
      E_HDR:  return 8'b0100_0001;
      E_DATA: return 8'b0010_0000;
      E_FULL: return 8'b0001_0001;
      E_RES:  return 8'b0000_1001;
      E_PAR:  return 8'b0000_0101;
      default: return 8'b0000_0011;
    endcase
  endfunction

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string rq, int ph);
    logic [7:0] act;
    act = {detect_o, hdr_ld_o, pay_ld_o, stall_o, resume_o, par_ld_o, chk_o, busy_o};
    checks++;
    if (act !== exp_of(ph)) begin
      errors++;
      $display("FAIL %s: outputs actual %b expected %b", rq, act, exp_of(ph));
    end
  endtask

  task automatic chk_dest(string rq, int d);
    checks++;
    if (dest_o !== 2'(d)) begin
      errors++;
      $display("FAIL %s: dest actual %0d expected %0d", rq, dest_o, d);
    end
  endtask

  task automatic send_pkt(int d, int wait_n, int pay_n, int full_at, int full_len);
    chk("R1_R8 decode", E_DEC);
    pkt_valid_i = 1; hdr_addr_i = 2'(d);
    fifo_empty_i = (wait_n > 0) ? ~(4'b1 << d) : 4'hF;
    step();
    hdr_addr_i = 2'(d + 1);  // later bytes carry other address bits
    for (int k = 0; k < wait_n; k++) begin
      chk("R3 wait", E_WAIT); chk_dest("R2 capture", d);
      fifo_empty_i = ~(4'b1 << d) ^ 4'(k);  // other ports toggle, dest stays busy
      if (k == wait_n - 1) fifo_empty_i = 4'hF;
      step();
    end
    chk("R2 header", E_HDR); chk_dest("R2 capture", d);
    step();
    for (int i = 0; i < pay_n; i++) begin
      chk("R4 payload", E_DATA);
      if (i == full_at) begin
        fifo_full_i = 1;
        if (i == pay_n - 1) pkt_valid_i = 0;  // R5 full wins
        step();
        for (int f = 0; f < full_len; f++) begin
          chk("R5 stall", E_FULL);
          if (f == full_len - 1) fifo_full_i = 0;
          step();
        end
        chk("R5 resume", E_RES);
      end
      if (i == pay_n - 1) pkt_valid_i = 0;
      step();
    end
    chk("R6_R7 parity load", E_PAR); chk_dest("R11 hold", d);
    step();
    chk("R7 check", E_CHK);
    step();
    chk("R7 back to decode", E_DEC);
  endtask

  initial begin
    #23; chk("R1 reset", E_DEC);
    rst_ni = 1; step();
    chk("R1 after release", E_DEC);
    for (int d = 0; d < 4; d++)
      for (int w = 0; w < 3; w++)
        for (int p = 1; p <= 3; p++)
          for (int fa = -1; fa < p; fa++)
            for (int fl = 1; fl <= 2; fl++)
              if (fa >= 0 || fl == 1) send_pkt(d, w, p, fa, fl);

    // R9: soft reset ignored in decode
    soft_rst_i = 4'hF; step(); soft_rst_i = 0;
    chk("R9 decode ignores soft reset", E_DEC);
    // R9: in wait, other port ignored, own port aborts
    pkt_valid_i = 1; hdr_addr_i = 2; fifo_empty_i = 4'b1011; step();
    chk("R3 wait", E_WAIT);
    soft_rst_i = 4'b1011; step(); soft_rst_i = 0;
    chk("R9 other port ignored", E_WAIT); chk_dest("R11 hold", 2);
    soft_rst_i = 4'b0100; step(); soft_rst_i = 0;
    chk("R9 abort from wait", E_DEC);
    // R9: abort during stall and during payload
    pkt_valid_i = 1; hdr_addr_i = 3; fifo_empty_i = 4'hF; step();
    chk("R2 header port 3", E_HDR); chk_dest("R2 capture", 3);
    step(); chk("R4 payload", E_DATA);
    fifo_full_i = 1; step(); chk("R5 stall", E_FULL);
    soft_rst_i = 4'b0111; step(); soft_rst_i = 0;
    chk("R9 other port ignored in stall", E_FULL);
    soft_rst_i = 4'b1000; step(); soft_rst_i = 0; fifo_full_i = 0;
    chk("R9 abort from stall", E_DEC);
    pkt_valid_i = 1; hdr_addr_i = 0; step(); step();
    chk("R4 payload", E_DATA);
    soft_rst_i = 4'b0001; step(); soft_rst_i = 0; pkt_valid_i = 0;
    chk("R9 abort from payload", E_DEC);
    step(); chk("R9 stays in decode", E_DEC);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule